// File: doc/BRIEF.md
# Multi-Group Event Interrupt Aggregator

This block gathers single-cycle event strobes from many hardware sources into three 32-bit pending words. Each event is named by a 7-bit identifier: the upper two bits pick the pending word and the lower five bits pick the bit inside it. A separate clear strobe, using the same identifier format, lets a source retire one pending bit without disturbing the others.

The pending array feeds three independent mask sets, one per interrupt line. Each mask set has one mask word per pending word. An interrupt line is high while at least one pending bit in any of the three words is also enabled in that line's mask set, and it falls only once no such bit remains anywhere. Software reads the pending and mask words over a simple word-addressed register bus. It writes the masks, and it retires pending bits by writing ones to the pending words.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every pending word, every mask word, `reg_rdata` for all offsets and all three bits of `irq_out` read zero.
- R2: A `ev_set_vld` strobe with identifier group `ev_set_id[6:5]` in 0..2 sets bit `ev_set_id[4:0]` of pending word `ev_set_id[6:5]`. The bit is visible on the register bus in the cycle after the strobe is sampled.
- R3: A `ev_clr_vld` strobe clears only bit `ev_clr_id[4:0]` of pending word `ev_clr_id[6:5]`. All other pending bits keep their values.
- R4: When a set and a clear, from either the clear strobe or a software write, hit the same pending bit in the same cycle, the bit ends up set.
- R5: A bus write to a pending word (offsets 0, 1, 2 for words 0, 1, 2) clears every pending bit whose written data bit is 1 and sets none. Writing all ones empties the word.
- R6: Mask words sit at offsets 4..6 (line A, words 0..2), 8..10 (line B) and 12..14 (line C). A write stores the data, and a read returns it in the same cycle as the address.
- R7: `irq_out[0]`, `irq_out[1]` and `irq_out[2]` (lines A, B, C) are registered. Each equals, one cycle late, the OR over all three words of (pending AND that line's mask word). A mask write or a pending change therefore shows on `irq_out` one clock after the register itself changes.
- R8: A line stays high after one of its contributing bits is cleared as long as another word or bit still gives a nonzero masked result. It drops only when every masked word is zero.
- R9: Set or clear strobes with identifier group 3 (`id[6:5]` = 3, ids 96..127) change no pending bit.
- R10: Offsets 3, 7, 11 and 15 are unmapped. They read zero, and writes to them change no pending or mask word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_set_vld | input | 1 | Single-cycle strobe that raises event `ev_set_id` |
| ev_set_id | input | 7 | Event to raise: [6:5] word, [4:0] bit |
| ev_clr_vld | input | 1 | Single-cycle strobe that retires event `ev_clr_id` |
| ev_clr_id | input | 7 | Event to retire: [6:5] word, [4:0] bit |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Word offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_out | output | 3 | Level interrupt lines: bit 0 A, bit 1 B, bit 2 C |

## Verification
A single event routed to one line, with the other two masks empty, shows whether the routing keeps the three mask sets apart. The same test also checks that the output lags the pending bit by one register. Several events, spread over different words and enabled on the same line, are then cleared one at a time; this separates a line that drops on the first clear from one that waits for the whole OR to empty. Coincident set and clear on one bit, all-ones and sparse software clears, and group-3 and unmapped-offset traffic each show whether the design follows the priority, picks the right bits, or leaks into state it must not touch.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int BIT_W   = 5;
  localparam int WORD_W  = 1 << BIT_W;
  localparam int GSEL_W  = 2;
  localparam int ID_W    = GSEL_W + BIT_W;
  localparam int NUM_GRP = 3;
  localparam int NUM_OUT = 3;
  localparam int ADDR_W  = 4;
  localparam int TOT_W   = NUM_GRP * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  // one-hot bit selected by the low part of an event identifier
  function automatic word_t id_bit(input logic [ID_W-1:0] id);
    word_t v;
    v = '0;
    v[id[BIT_W-1:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank
  import evt_irq_pkg::*;
#(
  parameter int N_GRP = NUM_GRP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_vld,
  input  logic [ID_W-1:0]        set_id,
  input  logic                   clr_vld,
  input  logic [ID_W-1:0]        clr_id,
  input  logic                   sw_clr_vld,
  input  logic [GSEL_W-1:0]      sw_clr_grp,
  input  word_t                  sw_clr_mask,
  output word_t [N_GRP-1:0]      pend_q
);

  for (genvar g = 0; g < N_GRP; g++) begin : g_word
    word_t set_vec;
    word_t clr_vec;
    word_t pend_d;
    word_t pend_r;
    logic  pend_en;

    always_comb begin
      set_vec = '0;
      clr_vec = '0;
      if (set_vld && (set_id[ID_W-1:BIT_W] == GSEL_W'(g)))
        set_vec = id_bit(set_id);
      if (clr_vld && (clr_id[ID_W-1:BIT_W] == GSEL_W'(g)))
        clr_vec = id_bit(clr_id);
      if (sw_clr_vld && (sw_clr_grp == GSEL_W'(g)))
        clr_vec = clr_vec | sw_clr_mask;
      pend_en = (|set_vec) | (|clr_vec);
      // a set on the same bit overrides any clear in this cycle
      pend_d  = (pend_r & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_r <= '0;
      else if (pend_en)
        pend_r <= pend_d;
    end

    assign pend_q[g] = pend_r;
  end

endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
  import evt_irq_pkg::*;
#(
  parameter int N_OUT = NUM_OUT,
  parameter int N_GRP = NUM_GRP
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [GSEL_W-1:0]             wr_set,
  input  logic [GSEL_W-1:0]             wr_word,
  input  word_t                         wr_data,
  output word_t [N_OUT-1:0][N_GRP-1:0]  mask_q
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_set
    for (genvar g = 0; g < N_GRP; g++) begin : g_word
      word_t mask_r;
      logic  mask_en;

      // set index 0 is the pending bank, so mask set k sits at k+1
      assign mask_en = wr_en && (wr_set == GSEL_W'(k + 1)) &&
                       (wr_word == GSEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mask_r <= '0;
        else if (mask_en)
          mask_r <= wr_data;
      end

      assign mask_q[k][g] = mask_r;
    end
  end

endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
  import evt_irq_pkg::*;
#(
  parameter int N_OUT = NUM_OUT,
  parameter int N_GRP = NUM_GRP
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  word_t [N_GRP-1:0]             pend,
  input  word_t [N_OUT-1:0][N_GRP-1:0]  mask,
  output logic  [N_OUT-1:0]             irq_q
);

  logic [N_OUT-1:0] irq_d;

  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      word_t acc;
      acc = '0;
      for (int g = 0; g < N_GRP; g++)
        acc = acc | (pend[g] & mask[k][g]);
      irq_d[k] = |acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= '0;
    else
      irq_q <= irq_d;
  end

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_set_vld,
  input  logic [ID_W-1:0]      ev_set_id,
  input  logic                 ev_clr_vld,
  input  logic [ID_W-1:0]      ev_clr_id,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_OUT-1:0]   irq_out
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [GSEL_W-1:0] acc_set;
  logic [GSEL_W-1:0] acc_word;
  logic              word_ok;
  logic              sw_clr_vld;

  assign acc_set    = reg_addr[ADDR_W-1:ADDR_W-GSEL_W];
  assign acc_word   = reg_addr[GSEL_W-1:0];
  assign word_ok    = (32'(acc_word) < NUM_GRP);
  assign sw_clr_vld = reg_we && (acc_set == '0) && word_ok;

  word_t [NUM_GRP-1:0]              pend_q;
  word_t [NUM_OUT-1:0][NUM_GRP-1:0] mask_q;

  evt_pend_bank #(.N_GRP(NUM_GRP)) u_pend (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .set_vld     (ev_set_vld),
    .set_id      (ev_set_id),
    .clr_vld     (ev_clr_vld),
    .clr_id      (ev_clr_id),
    .sw_clr_vld  (sw_clr_vld),
    .sw_clr_grp  (acc_word),
    .sw_clr_mask (reg_wdata),
    .pend_q      (pend_q)
  );

  evt_mask_bank #(.N_OUT(NUM_OUT), .N_GRP(NUM_GRP)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_we && word_ok),
    .wr_set  (acc_set),
    .wr_word (acc_word),
    .wr_data (reg_wdata),
    .mask_q  (mask_q)
  );

  evt_irq_route #(.N_OUT(NUM_OUT), .N_GRP(NUM_GRP)) u_route (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pend  (pend_q),
    .mask  (mask_q),
    .irq_q (irq_out)
  );

  // read mux: set 0 is pending, sets 1..3 are the mask sets
  always_comb begin
    reg_rdata = '0;
    if (word_ok) begin
      if (acc_set == '0)
        reg_rdata = pend_q[acc_word];
      else
        reg_rdata = mask_q[acc_set - 1'b1][acc_word];
    end
  end

endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk
  import evt_irq_pkg::*;
(
  input logic                              clk,
  input logic                              rst_n,
  input logic                              set_vld,
  input logic [ID_W-1:0]                   set_id,
  input logic                              clr_vld,
  input logic [ID_W-1:0]                   clr_id,
  input logic                              reg_we,
  input logic [ADDR_W-1:0]                 reg_addr,
  input logic [WORD_W-1:0]                 reg_wdata,
  input logic [TOT_W-1:0]                  pend,
  input logic [NUM_OUT-1:0][TOT_W-1:0]     mask,
  input logic [NUM_OUT-1:0]                irq
);

  logic [TOT_W-1:0]   set_flat;
  logic [TOT_W-1:0]   clr_flat;
  logic [TOT_W-1:0]   sw_flat;
  logic [NUM_OUT-1:0] hit;

  always_comb begin
    set_flat = '0;
    clr_flat = '0;
    sw_flat  = '0;
    if (set_vld && (32'(set_id) < TOT_W))
      set_flat = TOT_W'(1) << set_id;
    if (clr_vld && (32'(clr_id) < TOT_W))
      clr_flat = TOT_W'(1) << clr_id;
    if (reg_we && (reg_addr[ADDR_W-1:ADDR_W-GSEL_W] == '0) &&
        (32'(reg_addr[GSEL_W-1:0]) < NUM_GRP))
      sw_flat = TOT_W'(reg_wdata) << (32'(reg_addr[GSEL_W-1:0]) * WORD_W);
    for (int k = 0; k < NUM_OUT; k++)
      hit[k] = |(pend & mask[k]);
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flat != '0) |=> ((pend & $past(set_flat)) == $past(set_flat)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_flat != '0) && ((set_flat & (clr_flat | sw_flat)) != '0))
      |=> ((pend & $past(set_flat)) != '0));

  p_clr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_flat != '0) && !set_vld && !reg_we)
      |=> (pend == ($past(pend) & ~$past(clr_flat))));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_flat != '0) && !set_vld && !clr_vld)
      |=> (pend == ($past(pend) & ~$past(sw_flat))));

  p_grp3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && (32'(set_id) >= TOT_W) && !clr_vld && !reg_we)
      |=> $stable(pend));

  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(hit));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~hit) != '0) |=> ((irq & ~$past(irq)) == '0) || (hit != '0));

endmodule

bind evt_irq_agg evt_irq_agg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .set_vld   (ev_set_vld),
  .set_id    (ev_set_id),
  .clr_vld   (ev_clr_vld),
  .clr_id    (ev_clr_id),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pend      (pend_q),
  .mask      ({mask_q[2], mask_q[1], mask_q[0]}),
  .irq       (irq_out)
);

// File: tb/evt_irq_agg_test.sv
module evt_irq_agg_test;

  logic        clk;
  logic        rst_n;
  logic        ev_set_vld;
  logic [6:0]  ev_set_id;
  logic        ev_clr_vld;
  logic [6:0]  ev_clr_id;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_pend [3];
  logic [31:0] m_mask [3][3];

  evt_irq_agg uut (
    .clk(clk), .rst_n(rst_n),
    .ev_set_vld(ev_set_vld), .ev_set_id(ev_set_id),
    .ev_clr_vld(ev_clr_vld), .ev_clr_id(ev_clr_id),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2:0] m_irq();
    logic [2:0] r;
    for (int k = 0; k < 3; k++) begin
      logic [31:0] acc;
      acc = '0;
      for (int g = 0; g < 3; g++) acc = acc | (m_pend[g] & m_mask[k][g]);
      r[k] = |acc;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a[1:0] != 2'd3) begin
      if (a[3:2] == 2'd0) m_pend[a[1:0]] = m_pend[a[1:0]] & ~d;
      else m_mask[a[3:2] - 1][a[1:0]] = d;
    end
  endtask

  task automatic ev(bit sv, logic [6:0] sid, bit cv, logic [6:0] cid);
    @(negedge clk);
    ev_set_vld = sv; ev_set_id = sid; ev_clr_vld = cv; ev_clr_id = cid;
    @(negedge clk);
    ev_set_vld = 1'b0; ev_clr_vld = 1'b0;
    if (cv && cid < 7'd96) m_pend[cid[6:5]][cid[4:0]] = 1'b0;
    if (sv && sid < 7'd96) m_pend[sid[6:5]][sid[4:0]] = 1'b1;
  endtask

  // one more edge so the registered lines catch up, then compare everything
  task automatic check_all(string tag);
    @(negedge clk);
    check({tag, " irq"}, {29'd0, irq_out}, {29'd0, m_irq()});
    for (int g = 0; g < 3; g++) rd(4'(g), m_pend[g], {tag, " pend"});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ev_set_vld = 0; ev_set_id = '0; ev_clr_vld = 0; ev_clr_id = '0;
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
    for (int g = 0; g < 3; g++) begin
      m_pend[g] = '0;
      for (int k = 0; k < 3; k++) m_mask[k][g] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq", {29'd0, irq_out}, 32'd0);
    for (int a = 0; a < 16; a++) rd(4'(a), 32'd0, "R1 regs");
  endtask

  task automatic t_route_one();
    wr(4'd5, 32'h0000_0008);             // mask A word 1 bit 3
    ev(1'b1, 7'd35, 1'b0, 7'd0);         // word 1 bit 3
    rd(4'd1, 32'h0000_0008, "R2 pend");
    check("R7 lag", {29'd0, irq_out}, 32'd0);
    check_all("R7 route A");
    check("R7 only A", {29'd0, irq_out}, 32'd1);
  endtask

  task automatic t_mask_sets();
    wr(4'd10, 32'h8000_0000);            // mask B word 2 bit 31
    wr(4'd12, 32'h0000_0001);            // mask C word 0 bit 0
    rd(4'd10, 32'h8000_0000, "R6 maskB");
    rd(4'd12, 32'h0000_0001, "R6 maskC");
    ev(1'b1, 7'd95, 1'b0, 7'd0);
    check_all("R2 R7 B");
    ev(1'b1, 7'd0, 1'b0, 7'd0);
    check_all("R2 R7 C");
    check("R7 all", {29'd0, irq_out}, 32'd7);
  endtask

  task automatic t_clear_hold();
    wr(4'd4, 32'h0000_0100);             // mask A word 0 bit 8
    ev(1'b1, 7'd8, 1'b0, 7'd0);
    ev(1'b1, 7'd36, 1'b0, 7'd0);         // unmasked neighbour in word 1
    ev(1'b0, 7'd0, 1'b1, 7'd35);         // clear word 1 bit 3
    check_all("R3 clr");
    rd(4'd1, 32'h0000_0010, "R3 neighbour kept");
    check("R8 hold", {31'd0, irq_out[0]}, 32'd1);
    ev(1'b0, 7'd0, 1'b1, 7'd8);
    check_all("R8 drop");
    check("R8 A low", {31'd0, irq_out[0]}, 32'd0);
  endtask

  task automatic t_set_wins();
    ev(1'b1, 7'd70, 1'b1, 7'd70);
    check_all("R4 hw");
    rd(4'd2, m_pend[2], "R4 bit");
    @(negedge clk);
    ev_set_vld = 1'b1; ev_set_id = 7'd71;
    reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    ev_set_vld = 1'b0; reg_we = 1'b0;
    m_pend[2] = 32'h0000_0080;
    check_all("R4 sw");
  endtask

  task automatic t_w1c();
    ev(1'b1, 7'd1, 1'b0, 7'd0);
    ev(1'b1, 7'd2, 1'b0, 7'd0);
    ev(1'b1, 7'd3, 1'b0, 7'd0);
    wr(4'd0, 32'h0000_0004);
    check_all("R5 sparse");
    rd(4'd0, 32'h0000_000B, "R5 sparse word");
    wr(4'd0, 32'hFFFF_FFFF);
    check_all("R5 all ones");
    rd(4'd0, 32'd0, "R5 empty");
  endtask

  task automatic t_mask_write();
    ev(1'b1, 7'd40, 1'b0, 7'd0);
    wr(4'd13, 32'h0000_0100);            // mask C word 1 bit 8
    check("R7 mask lag", {31'd0, irq_out[2]}, 32'd0);
    check_all("R6 R7 mask");
    check("R7 mask on", {31'd0, irq_out[2]}, 32'd1);
  endtask

  task automatic t_grp3();
    ev(1'b1, 7'd100, 1'b0, 7'd0);
    check_all("R9 set");
    ev(1'b0, 7'd0, 1'b1, 7'd104);        // aliases word 0 bit 8 if decoded wrongly
    check_all("R9 clr");
  endtask

  task automatic t_unmapped();
    wr(4'd3,  32'hFFFF_FFFF);
    wr(4'd7,  32'h1234_5678);
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    for (int a = 3; a < 16; a += 4) rd(4'(a), 32'd0, "R10 read");
    check_all("R10 state");
    for (int k = 0; k < 3; k++)
      for (int g = 0; g < 3; g++)
        rd(4'(4 * (k + 1) + g), m_mask[k][g], "R10 masks");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_route_one();
    t_mask_sets();
    t_clear_hold();
    t_set_wins();
    t_w1c();
    t_mask_write();
    t_grp3();
    t_unmapped();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule